// File: doc/BRIEF.md
# UART status and interrupt unit

This block keeps the status flags and the interrupt-enable register of a FIFO-based UART, and from them it drives an error interrupt and a combined peripheral interrupt. The transmit and receive FIFOs and the receiver's error checks live elsewhere. They reach this block only as one-cycle event strobes: data written, character sent, FIFO threshold reached, entry pushed or popped, and overrun. Software cannot write any status flag. Each flag is set by one hardware event and cleared by another.

Parity and framing errors are tagged per received character. The block keeps a small tag queue that runs in step with the receive FIFO. The two error flags always show the tag of the character now at the head, so each clears when that character is read out. A register port in the style of APB gives read/write access to the enable register and read-only access to the status register. Both interrupt outputs are registered, and the interrupt tree has two levels: the enabled error bits are ORed into the error interrupt, and that result is ORed with the enabled FIFO-level bits to form the overall interrupt.

Top module: `uart_status_irq`

## Requirements
- R1: After a synchronous reset, every status flag, the enable register, and both interrupt outputs are 0.
- R2: The enable register is 8 bits wide and sits at byte offset 0x10. It is written when sel, enable and write are all high, and read back in prdata[7:0] when sel is high and write is low. The status register reads at offset 0x14. Any other offset reads 0.
- R3: A write to the status offset 0x14 changes neither the status flags nor the enable register.
- R4: Status bit positions are: 0 receive-full, 1 receive-half-full, 2 transmit-empty, 3 transmit-half-empty, 4 transmit-full, 5 parity error, 6 framing error, 7 overrun. Each event flag is set one cycle after its set strobe. When a set strobe and a clear strobe arrive in the same cycle, the set wins.
- R5: A transmit write strobe clears transmit-empty (bit 2) and transmit-half-empty (bit 3).
- R6: A character-sent strobe clears transmit-full (bit 4).
- R7: A receive read strobe clears receive-full (bit 0), receive-half-full (bit 1) and overrun (bit 7).
- R8: Each receive push stores a parity tag and a framing tag. Bits 5 and 6 show the tags of the oldest stored entry and read 0 when no entry is stored. A receive read drops the oldest entry. A push that arrives while TAG_DEPTH entries are held, with no read in the same cycle, is discarded.
- R9: err_irq is the OR of status bits 5, 6 and 7, each ANDed with the matching enable bit. It is registered, so it follows the status and enable values one cycle later.
- R10: irq is the registered OR of the error term and the enabled bits 0 to 3. It is therefore high whenever err_irq is high.
- R11: Transmit-full (bit 4) never raises either interrupt, even when its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | Character written into transmit buffer |
| tx_sent | input | 1 | Character shifted out by transmitter |
| tx_empty_set | input | 1 | Transmit FIFO became empty |
| tx_half_set | input | 1 | Transmit FIFO reached half-empty |
| tx_full_set | input | 1 | Transmit FIFO became full |
| rx_push | input | 1 | Character pushed into receive FIFO |
| rx_par | input | 1 | Parity error tag of pushed character |
| rx_frm | input | 1 | Framing error tag of pushed character |
| rx_rd | input | 1 | Character read from receive FIFO |
| rx_full_set | input | 1 | Receive FIFO became full |
| rx_half_set | input | 1 | Receive FIFO reached half-full |
| rx_ovr_set | input | 1 | Receive overrun detected |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write when high |
| paddr | input | ADDR_W | Register byte offset |
| pwdata | input | DATA_W | Register write data |
| prdata | output | DATA_W | Register read data |
| err_irq | output | 1 | Registered error interrupt |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with TAG_DEPTH=4, an 8-bit address and a 32-bit data port. A queue of four entries fills after four pushes, so a fifth push, the one that must be discarded, can be driven in a short directed sequence. Random traffic with frequent pushes and rare reads also keeps the queue at its limit, and there it meets simultaneous push-and-read cycles. Each cycle the bench checks the random set/clear collisions, writes to the status offset, and enable patterns against a bench-side model of the flags, the tag queue and the two interrupts.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSTAT = 8;
    localparam int NEVT  = 6;

    // Status register image, bit 7 down to bit 0
    typedef struct packed {
        logic ovr;
        logic frm;
        logic par;
        logic txf;
        logic txh;
        logic txe;
        logic rxh;
        logic rxf;
    } ustat_t;

    // Per-character error tag kept beside the receive data
    typedef struct packed {
        logic par;
        logic frm;
    } tag_t;

    // Event-flag bank slot indices
    localparam int EV_RXF = 0;
    localparam int EV_RXH = 1;
    localparam int EV_TXE = 2;
    localparam int EV_TXH = 3;
    localparam int EV_TXF = 4;
    localparam int EV_OVR = 5;

    localparam logic [NSTAT-1:0] ERR_MASK = 8'b1110_0000;
    localparam logic [NSTAT-1:0] LVL_MASK = 8'b0000_1111;
    localparam logic [NSTAT-1:0] TXF_MASK = 8'b0001_0000;

    localparam logic [7:0] OFS_IEN  = 8'h10;
    localparam logic [7:0] OFS_STAT = 8'h14;

    function automatic logic masked_any(
        input logic [NSTAT-1:0] s,
        input logic [NSTAT-1:0] e,
        input logic [NSTAT-1:0] m
    );
        return |(s & e & m);
    endfunction

endpackage

// File: rtl/uart_evt_flags.sv
module uart_evt_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= 1'b1;
            else if (clr[i])
                q[i] <= 1'b0;
        end

        a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> q[i]);
    end

endmodule

// File: rtl/uart_err_tag_fifo.sv
module uart_err_tag_fifo
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  tag_t push_tag,
    input  logic pop,
    output tag_t head_tag,
    output logic head_valid
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

    tag_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_pop, do_push;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign do_pop  = pop && (cnt != '0);
    assign do_push = push && ((cnt != FULLC) || do_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_tag;
    end

    assign head_valid = (cnt != '0);
    assign head_tag   = head_valid ? mem[rd_ptr] : '0;

    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULLC);
    a_r8_drop_full: assert property (@(posedge clk) disable iff (rst)
        (cnt == FULLC && push && !pop) |=> (cnt == FULLC));

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSTAT-1:0]  status,
    output logic [NSTAT-1:0]  ien,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic ien_we, stat_we;
    logic unused_wdata_hi;

    assign ien_we  = sel && en && wr && (addr == A_IEN);
    assign stat_we = sel && en && wr && (addr == A_STAT);
    assign unused_wdata_hi = ^wdata[DATA_W-1:NSTAT];

    always_ff @(posedge clk) begin
        if (rst)
            ien <= '0;
        else if (ien_we)
            ien <= wdata[NSTAT-1:0];
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            if (addr == A_IEN)
                rdata[NSTAT-1:0] = ien;
            else if (addr == A_STAT)
                rdata[NSTAT-1:0] = status;
        end
    end

    a_r3_stat_write_keeps_ien: assert property (@(posedge clk) disable iff (rst)
        stat_we |=> $stable(ien));

endmodule

// File: rtl/uart_irq_tree.sv
module uart_irq_tree
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTAT-1:0] status,
    input  logic [NSTAT-1:0] ien,
    output logic             err_irq,
    output logic             irq
);

    logic err_d, lvl_d;

    assign err_d = masked_any(status, ien, ERR_MASK);
    assign lvl_d = masked_any(status, ien, LVL_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_irq <= 1'b0;
            irq     <= 1'b0;
        end else begin
            err_irq <= err_d;
            irq     <= err_d | lvl_d;
        end
    end

    a_r10_err_in_irq: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> irq);

endmodule

// File: rtl/uart_status_irq.sv
module uart_status_irq
    import uart_irq_pkg::*;
#(
    parameter int TAG_DEPTH = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_wr,
    input  logic              tx_sent,
    input  logic              tx_empty_set,
    input  logic              tx_half_set,
    input  logic              tx_full_set,
    input  logic              rx_push,
    input  logic              rx_par,
    input  logic              rx_frm,
    input  logic              rx_rd,
    input  logic              rx_full_set,
    input  logic              rx_half_set,
    input  logic              rx_ovr_set,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              err_irq,
    output logic              irq
);

    logic [NEVT-1:0]  ev_set, ev_clr, ev_q;
    tag_t             push_tag, head_tag;
    logic             head_valid;
    ustat_t           st;
    logic [NSTAT-1:0] stat_vec, ien;

    always_comb begin
        ev_set = '0;
        ev_clr = '0;
        ev_set[EV_RXF] = rx_full_set;
        ev_set[EV_RXH] = rx_half_set;
        ev_set[EV_TXE] = tx_empty_set;
        ev_set[EV_TXH] = tx_half_set;
        ev_set[EV_TXF] = tx_full_set;
        ev_set[EV_OVR] = rx_ovr_set;
        ev_clr[EV_RXF] = rx_rd;
        ev_clr[EV_RXH] = rx_rd;
        ev_clr[EV_TXE] = tx_wr;
        ev_clr[EV_TXH] = tx_wr;
        ev_clr[EV_TXF] = tx_sent;
        ev_clr[EV_OVR] = rx_rd;
    end

    uart_evt_flags #(.N(NEVT)) u_flags (
        .clk (clk),
        .rst (rst),
        .set (ev_set),
        .clr (ev_clr),
        .q   (ev_q)
    );

    assign push_tag.par = rx_par;
    assign push_tag.frm = rx_frm;

    uart_err_tag_fifo #(.DEPTH(TAG_DEPTH)) u_tags (
        .clk        (clk),
        .rst        (rst),
        .push       (rx_push),
        .push_tag   (push_tag),
        .pop        (rx_rd),
        .head_tag   (head_tag),
        .head_valid (head_valid)
    );

    always_comb begin
        st.rxf = ev_q[EV_RXF];
        st.rxh = ev_q[EV_RXH];
        st.txe = ev_q[EV_TXE];
        st.txh = ev_q[EV_TXH];
        st.txf = ev_q[EV_TXF];
        st.ovr = ev_q[EV_OVR];
        st.par = head_valid & head_tag.par;
        st.frm = head_valid & head_tag.frm;
    end

    assign stat_vec = st;

    uart_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .sel    (psel),
        .en     (penable),
        .wr     (pwrite),
        .addr   (paddr),
        .wdata  (pwdata),
        .status (stat_vec),
        .ien    (ien),
        .rdata  (prdata)
    );

    uart_irq_tree u_tree (
        .clk     (clk),
        .rst     (rst),
        .status  (stat_vec),
        .ien     (ien),
        .err_irq (err_irq),
        .irq     (irq)
    );

    a_r5_tx_wr_clears: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && !tx_empty_set && !tx_half_set) |=> (!st.txe && !st.txh));
    a_r6_sent_clears: assert property (@(posedge clk) disable iff (rst)
        (tx_sent && !tx_full_set) |=> !st.txf);
    a_r7_rd_clears: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && !rx_full_set && !rx_ovr_set) |=> (!st.rxf && !st.ovr));
    a_r11_txf_silent: assert property (@(posedge clk) disable iff (rst)
        ((stat_vec & ien & ~TXF_MASK) == '0) |=> !irq);

endmodule

// File: tb/sim_uart_status_irq.sv
`timescale 1ns/1ps
module sim_uart_status_irq;

    localparam int TD = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        tx_wr, tx_sent, tx_empty_set, tx_half_set, tx_full_set;
    logic        rx_push, rx_par, rx_frm, rx_rd, rx_full_set, rx_half_set, rx_ovr_set;
    logic        psel, penable, pwrite;
    logic [7:0]  paddr;
    logic [31:0] pwdata, prdata;
    logic        err_irq, irq;

    uart_status_irq #(.TAG_DEPTH(TD), .ADDR_W(8), .DATA_W(32)) u0 (
        .clk(clk), .rst(rst),
        .tx_wr(tx_wr), .tx_sent(tx_sent), .tx_empty_set(tx_empty_set),
        .tx_half_set(tx_half_set), .tx_full_set(tx_full_set),
        .rx_push(rx_push), .rx_par(rx_par), .rx_frm(rx_frm), .rx_rd(rx_rd),
        .rx_full_set(rx_full_set), .rx_half_set(rx_half_set), .rx_ovr_set(rx_ovr_set),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .err_irq(err_irq), .irq(irq)
    );

    int    total = 0;
    int    bad   = 0;
    string cur_tag = "R4";

    // bench model
    logic       m_rxf, m_rxh, m_txe, m_txh, m_txf, m_ovr;
    logic [1:0] mq [TD];
    int         mrd, mcnt;
    logic [7:0] m_en;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status();
        logic [1:0] h;
        h = (mcnt > 0) ? mq[mrd] : 2'b00;
        return {m_ovr, h[0], h[1], m_txf, m_txh, m_txe, m_rxh, m_rxf};
    endfunction

    function automatic logic [31:0] m_read();
        if (paddr == 8'h10) return {24'h0, m_en};
        if (paddr == 8'h14) return {24'h0, m_status()};
        return 32'h0;
    endfunction

    task automatic idle();
        tx_wr = 0; tx_sent = 0; tx_empty_set = 0; tx_half_set = 0; tx_full_set = 0;
        rx_push = 0; rx_par = 0; rx_frm = 0; rx_rd = 0;
        rx_full_set = 0; rx_half_set = 0; rx_ovr_set = 0;
        psel = 0; penable = 0; pwrite = 0; paddr = 8'h00; pwdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] a);
        psel = 1; penable = 1; pwrite = 0; paddr = a;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1; penable = 1; pwrite = 1; paddr = a; pwdata = d;
    endtask

    task automatic step();
        logic [7:0] s;
        logic e_err, e_irq, pop, push;
        int widx;
        @(posedge clk);
        s = m_status();
        e_err = |(s & m_en & 8'hE0);
        e_irq = e_err | (|(s & m_en & 8'h0F));
        if (rx_full_set) m_rxf = 1; else if (rx_rd) m_rxf = 0;
        if (rx_half_set) m_rxh = 1; else if (rx_rd) m_rxh = 0;
        if (tx_empty_set) m_txe = 1; else if (tx_wr) m_txe = 0;
        if (tx_half_set) m_txh = 1; else if (tx_wr) m_txh = 0;
        if (tx_full_set) m_txf = 1; else if (tx_sent) m_txf = 0;
        if (rx_ovr_set) m_ovr = 1; else if (rx_rd) m_ovr = 0;
        pop  = rx_rd && (mcnt > 0);
        push = rx_push && ((mcnt < TD) || pop);
        widx = (mrd + mcnt) % TD;
        if (push) mq[widx] = {rx_par, rx_frm};
        if (pop) mrd = (mrd + 1) % TD;
        mcnt = mcnt + (push ? 1 : 0) - (pop ? 1 : 0);
        if (psel && penable && pwrite && paddr == 8'h10) m_en = pwdata[7:0];
        @(negedge clk);
        chk("R9 err_irq", {31'h0, err_irq}, {31'h0, e_err});
        chk("R10 irq", {31'h0, irq}, {31'h0, e_irq});
        if (psel && !pwrite) chk({cur_tag, " read"}, prdata, m_read());
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        rst = 1;
        m_rxf = 0; m_rxh = 0; m_txe = 0; m_txh = 0; m_txf = 0; m_ovr = 0;
        mrd = 0; mcnt = 0; m_en = 8'h00;
        for (int i = 0; i < TD; i++) mq[i] = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 err_irq", {31'h0, err_irq}, 32'h0);
        rd(8'h14);
        #1 chk("R1 status", prdata, 32'h0);
        rd(8'h10);
        #1 chk("R1 ien", prdata, 32'h0);
        idle();
        rst = 0;

        // R2 enable readback
        wr(8'h10, 32'hFFFF_FFFF); step(); idle();
        cur_tag = "R2"; rd(8'h10); step();
        chk("R2 ien readback", prdata, 32'h0000_00FF);
        rd(8'h08); step();
        chk("R2 other offset", prdata, 32'h0);
        idle();

        // R3 status write ignored
        wr(8'h14, 32'hFF); step(); idle();
        cur_tag = "R3"; rd(8'h14); step();
        chk("R3 status after write", prdata, 32'h0);
        rd(8'h10); step();
        chk("R3 ien after status write", prdata, 32'hFF);
        idle();

        // R11 transmit-full raises nothing
        cur_tag = "R11"; tx_full_set = 1; rd(8'h14); step(); idle();
        chk("R11 status txf", prdata, 32'h10);
        rd(8'h14); step();
        chk("R11 irq", {31'h0, irq}, 32'h0);
        rd(8'h14); step();
        chk("R11 err_irq", {31'h0, err_irq}, 32'h0);
        idle();

        // R4 set beats clear
        cur_tag = "R4"; tx_empty_set = 1; tx_wr = 1; rd(8'h14); step(); idle();
        chk("R4 set wins", prdata, 32'h14);
        rd(8'h14); step();
        chk("R10 irq from txe", {31'h0, irq}, 32'h1);
        idle();

        // R5 transmit write clears empty/half
        tx_half_set = 1; step(); idle();
        cur_tag = "R5"; tx_wr = 1; rd(8'h14); step(); idle();
        chk("R5 tx clears", prdata, 32'h10);

        // R6 sent clears full
        cur_tag = "R6"; tx_sent = 1; rd(8'h14); step(); idle();
        chk("R6 sent clears", prdata, 32'h0);

        // R7 receive read clears
        cur_tag = "R7"; rx_full_set = 1; rx_half_set = 1; rx_ovr_set = 1;
        rd(8'h14); step(); idle();
        chk("R7 set", prdata, 32'h83);
        rd(8'h14); step();
        chk("R9 ovr err_irq", {31'h0, err_irq}, 32'h1);
        rx_rd = 1; step(); idle();
        chk("R7 rd clears", prdata, 32'h0);

        // R8 tag queue
        cur_tag = "R8";
        rx_push = 1; rx_par = 1; rd(8'h14); step(); idle();
        chk("R8 parity head", prdata, 32'h20);
        rx_push = 1; step(); idle();
        rx_push = 1; rx_frm = 1; step(); idle();
        rd(8'h14); step();
        chk("R8 head kept", prdata, 32'h20);
        rx_rd = 1; step(); idle();
        chk("R8 parity cleared", prdata, 32'h0);
        rx_rd = 1; rd(8'h14); step(); idle();
        chk("R8 framing head", prdata, 32'h40);
        rx_rd = 1; rd(8'h14); step(); idle();
        chk("R8 empty", prdata, 32'h0);
        for (int i = 0; i < TD; i++) begin rx_push = 1; step(); idle(); end
        rx_push = 1; rx_par = 1; step(); idle();
        for (int i = 0; i < TD; i++) begin rx_rd = 1; rd(8'h14); step(); idle(); end
        rd(8'h14); step();
        chk("R8 drop when full", prdata, 32'h0);
        idle();

        // random traffic
        cur_tag = "R4";
        for (int n = 0; n < 3000; n++) begin
            int b;
            tx_wr        = ($urandom % 8) == 0;
            tx_sent      = ($urandom % 8) == 0;
            tx_empty_set = ($urandom % 8) == 0;
            tx_half_set  = ($urandom % 8) == 0;
            tx_full_set  = ($urandom % 8) == 0;
            rx_push      = ($urandom % 3) == 0;
            rx_par       = ($urandom % 4) == 0;
            rx_frm       = ($urandom % 4) == 0;
            rx_rd        = ($urandom % 6) == 0;
            rx_full_set  = ($urandom % 8) == 0;
            rx_half_set  = ($urandom % 8) == 0;
            rx_ovr_set   = ($urandom % 10) == 0;
            b = $urandom % 16;
            if (b < 2) wr(8'h10, $urandom);
            else if (b < 3) wr(8'h14, $urandom);
            else if (b < 11) rd(8'h14);
            else if (b < 14) rd(8'h10);
            else rd(8'($urandom));
            step();
            idle();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule